// File: doc/BRIEF.md
# Reloading Countdown Timer with Two-Output Interrupt Routing

This block holds a periodic countdown timer and the pending flags for six interrupt causes, and routes them to two active-low outputs: a normal interrupt line (`irq_n`) and a fast interrupt line (`firq_n`). Each output has its own six-bit enable register and a global output-enable bit in the control register. A cause reaches an output only when its flag is pending, its bit is set in that output's enable register, and the output's global enable is set.

The timer takes a reload value written as a low byte and a high part. Writing the high part copies the full reload value into the counter and starts it. Each enabled tick lowers the count by one. The tick is the fast tick when the clock-select bit is 0 and the slow, line-rate tick when it is 1. When the count reaches zero, the timer flag is latched, the counter reloads and counting goes on. A reload value of zero parks the timer. The five external causes are latched on their rising edges. Reading an enable register returns the enabled pending flags and clears the external ones among them. The timer flag is cleared only by writing its enable bit from 1 to 0.

The timer controller is a two-state machine. In `TMR_IDLE` nothing counts. The transition *start* (high-part write with a nonzero value) enters `TMR_RUN`. In `TMR_RUN` the transition *step* (selected tick, count above 1) decrements. The transition *expire* (selected tick, count 1) latches the flag and reloads. The transition *park* (high-part write of zero, or expiry with a reload value now zero) returns to `TMR_IDLE`.

Top module: `tmr_irq_router`

## Requirements
- R1: After reset `irq_n` and `firq_n` are 1, the control, enable and reload registers read 0, and the timer is idle.
- R2: A write to address 3 (reload bits 11:8 in data bits 3:0) loads the counter from the full reload value and starts it. A write to address 4 (reload bits 7:0) only changes the stored value and does not start a stopped timer.
- R3: Control bit 2 selects the decrement tick: 0 uses `tick_fast`, 1 uses `tick_slow`. The unselected tick has no effect.
- R4: With reload value N, the timer flag (pending bit 5) is set on the Nth selected tick after the start. The counter then reloads N and continues, so the flag is set again every N ticks.
- R5: A reload value of 0 leaves the timer stopped, and no timer flag is ever raised from it.
- R6: A rising edge on `src_in[k]` sets pending bit k. The bits are: 4 horizontal border, 3 vertical border, 2 serial input, 1 keyboard, 0 cartridge. A level held high sets the bit only once.
- R7: `irq_n` is 0 exactly when control bit 0 is 1 and a pending bit is also set in the IRQ enable register (address 1). `firq_n` is 0 exactly when control bit 1 is 1 and a pending bit is also set in the FIRQ enable register (address 2). Both registers use the bit layout of R6 with bit 5 for the timer.
- R8: A cause enabled in both enable registers drives both outputs low at once.
- R9: Reading address 1 or 2 returns the pending flags ANDed with that register's enables. The external flags returned are cleared, and the timer flag is left set.
- R10: A write to address 1 or 2 that changes enable bit 5 from 1 to 0 clears the timer flag. Setting the bit again does not bring the flag back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read-clear side effect) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| tick_fast | input | 1 | Fast-rate decrement enable |
| tick_slow | input | 1 | Line-rate decrement enable |
| src_in | input | 5 | External interrupt causes, latched on rising edge |
| irq_n | output | 1 | Normal interrupt, active low |
| firq_n | output | 1 | Fast interrupt, active low |

## Verification
A register write, a selected tick or a source edge is captured at the next rising edge, and `irq_n` and `firq_n` follow combinationally from the flags. Every result is therefore due one edge after its stimulus. The bench drives inputs on falling edges and checks the outputs on the following falling edge. Read data is combinational, so it is sampled shortly after the read strobe is driven, and the read-clear effect is checked on the next falling edge. Tick counts are exact: each case checks the output one tick before and at the expected expiry.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;

    typedef enum logic [0:0] {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;

    localparam logic [2:0] A_CTRL   = 3'd0;
    localparam logic [2:0] A_IRQEN  = 3'd1;
    localparam logic [2:0] A_FIRQEN = 3'd2;
    localparam logic [2:0] A_CNTHI  = 3'd3;
    localparam logic [2:0] A_CNTLO  = 3'd4;

    localparam int N_CAUSE = 6;
    localparam int TMR_BIT = 5;

    localparam int CTRL_IRQ_OE  = 0;
    localparam int CTRL_FIRQ_OE = 1;
    localparam int CTRL_SLOW    = 2;

endpackage

// File: rtl/tmr_countdown.sv
module tmr_countdown
    import tmr_irq_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             tick,
    output logic             expire,
    output tmr_state_e       state,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;

    // output process: expiry strobe
    always_comb begin
        expire = (state_q == TMR_RUN) && tick && (count_q == ONE) && !load;
    end

    // next-state and next-count
    always_comb begin
        state_d = state_q;
        count_d = count_q;
        if (load) begin
            count_d = load_val;
            state_d = (load_val == ZERO) ? TMR_IDLE : TMR_RUN;
        end else begin
            unique case (state_q)
                TMR_IDLE: begin
                    state_d = TMR_IDLE;
                end
                TMR_RUN: begin
                    if (expire) begin
                        count_d = reload_val;
                        state_d = (reload_val == ZERO) ? TMR_IDLE : TMR_RUN;
                    end else if (tick) begin
                        count_d = count_q - ONE;
                    end
                end
                default: state_d = TMR_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
            count_q <= ZERO;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    assign state = state_q;
    assign count = count_q;

endmodule

// File: rtl/irq_pending.sv
module irq_pending
    import tmr_irq_pkg::*;
#(
    parameter int NC = N_CAUSE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NC-2:0] src_in,
    input  logic          tmr_set,
    input  logic          tmr_clr,
    input  logic [NC-2:0] rd_clr,
    output logic [NC-1:0] pend
);

    logic [NC-2:0] src_q;
    logic [NC-2:0] rise;
    logic [NC-1:0] pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_in;
    end

    assign rise = src_in & ~src_q;

    for (genvar i = 0; i < NC - 1; i++) begin : g_ext
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         pend_q[i] <= 1'b0;
            else if (rise[i])   pend_q[i] <= 1'b1;
            else if (rd_clr[i]) pend_q[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pend_q[NC-1] <= 1'b0;
        else if (tmr_set) pend_q[NC-1] <= 1'b1;
        else if (tmr_clr) pend_q[NC-1] <= 1'b0;
    end

    assign pend = pend_q;

endmodule

// File: rtl/tmr_irq_router.sv
module tmr_irq_router
    import tmr_irq_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       tick_fast,
    input  logic       tick_slow,
    input  logic [4:0] src_in,
    output logic       irq_n,
    output logic       firq_n
);

    localparam int HI_W = CNT_W - 8;
    localparam int NC   = N_CAUSE;

    logic [2:0]       ctrl_q;
    logic [NC-1:0]    irq_en_q, firq_en_q;
    logic [HI_W-1:0]  rl_hi_q;
    logic [7:0]       rl_lo_q;
    logic [CNT_W-1:0] reload_cur, load_val;
    logic             load, tick, expire, tmr_clr;
    logic [NC-2:0]    rd_clr;
    logic [NC-1:0]    pend;
    tmr_state_e       tmr_state;
    logic [CNT_W-1:0] tmr_count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            irq_en_q  <= '0;
            firq_en_q <= '0;
            rl_hi_q   <= '0;
            rl_lo_q   <= '0;
        end else if (wr_en) begin
            unique case (addr)
                A_CTRL:   ctrl_q    <= wdata[2:0];
                A_IRQEN:  irq_en_q  <= wdata[NC-1:0];
                A_FIRQEN: firq_en_q <= wdata[NC-1:0];
                A_CNTHI:  rl_hi_q   <= wdata[HI_W-1:0];
                A_CNTLO:  rl_lo_q   <= wdata;
                default:  ;
            endcase
        end
    end

    assign reload_cur = {rl_hi_q, rl_lo_q};
    assign load       = wr_en && (addr == A_CNTHI);
    assign load_val   = {wdata[HI_W-1:0], rl_lo_q};
    assign tick       = ctrl_q[CTRL_SLOW] ? tick_slow : tick_fast;

    always_comb begin
        tmr_clr = 1'b0;
        if (wr_en && !wdata[TMR_BIT]) begin
            if (addr == A_IRQEN  && irq_en_q[TMR_BIT])  tmr_clr = 1'b1;
            if (addr == A_FIRQEN && firq_en_q[TMR_BIT]) tmr_clr = 1'b1;
        end
    end

    always_comb begin
        rd_clr = '0;
        if (rd_en) begin
            if (addr == A_IRQEN)  rd_clr = irq_en_q[NC-2:0];
            if (addr == A_FIRQEN) rd_clr = firq_en_q[NC-2:0];
        end
    end

    always_comb begin
        unique case (addr)
            A_CTRL:   rdata = {5'b0, ctrl_q};
            A_IRQEN:  rdata = {{(8-NC){1'b0}}, pend & irq_en_q};
            A_FIRQEN: rdata = {{(8-NC){1'b0}}, pend & firq_en_q};
            A_CNTHI:  rdata = {{(8-HI_W){1'b0}}, rl_hi_q};
            A_CNTLO:  rdata = rl_lo_q;
            default:  rdata = 8'h00;
        endcase
    end

    tmr_countdown #(.CNT_W(CNT_W)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_val   (load_val),
        .reload_val (reload_cur),
        .tick       (tick),
        .expire     (expire),
        .state      (tmr_state),
        .count      (tmr_count)
    );

    irq_pending #(.NC(NC)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_in  (src_in),
        .tmr_set (expire),
        .tmr_clr (tmr_clr),
        .rd_clr  (rd_clr),
        .pend    (pend)
    );

    assign irq_n  = ~(ctrl_q[CTRL_IRQ_OE]  & |(pend & irq_en_q));
    assign firq_n = ~(ctrl_q[CTRL_FIRQ_OE] & |(pend & firq_en_q));

endmodule

// File: rtl/tmr_irq_router_chk.sv
module tmr_irq_router_chk
    import tmr_irq_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [2:0]       addr,
    input logic [7:0]       wdata,
    input logic [4:0]       src_in,
    input logic             irq_n,
    input logic             firq_n,
    input logic [2:0]       ctrl_q,
    input logic [5:0]       irq_en_q,
    input logic [5:0]       pend,
    input logic             expire,
    input tmr_state_e       tmr_state,
    input logic [CNT_W-1:0] tmr_count,
    input logic [CNT_W-1:0] reload_cur
);

    localparam int HI_W = CNT_W - 8;

    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (ctrl_q[CTRL_IRQ_OE] && |(pend & irq_en_q)));

    // R7
    firq_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[CTRL_FIRQ_OE] |-> firq_n);

    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_state == TMR_IDLE) |-> !expire);

    // R4
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !(wr_en && addr == A_CNTHI)) |=> (tmr_count == $past(reload_cur)));

    // R4
    tmr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> pend[TMR_BIT]);

    // R6
    src_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_in[0]) |=> pend[0]);

    // R10
    tmr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_IRQEN && irq_en_q[TMR_BIT] && !wdata[TMR_BIT] && !expire)
        |=> !pend[TMR_BIT]);

    // R2
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CNTHI && wdata[HI_W-1:0] != '0) |=> (tmr_state == TMR_RUN));

endmodule

bind tmr_irq_router tmr_irq_router_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .src_in     (src_in),
    .irq_n      (irq_n),
    .firq_n     (firq_n),
    .ctrl_q     (ctrl_q),
    .irq_en_q   (irq_en_q),
    .pend       (pend),
    .expire     (expire),
    .tmr_state  (tmr_state),
    .tmr_count  (tmr_count),
    .reload_cur (reload_cur)
);

// File: tb/tmr_irq_router_tb.sv
module tmr_irq_router_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       tick_fast = 1'b0;
    logic       tick_slow = 1'b0;
    logic [4:0] src_in = '0;
    logic       irq_n, firq_n;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_irq_router #(.CNT_W(12)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tick_fast(tick_fast), .tick_slow(tick_slow),
        .src_in(src_in), .irq_n(irq_n), .firq_n(firq_n)
    );

    typedef struct packed {
        logic [11:0] rl;
        logic [9:0]  nt;
        logic        sel;
        logic        line_slow;
        logic        exp_low;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{12'd3,   10'd2,   1'b0, 1'b0, 1'b0},  // R4 one tick short
        '{12'd3,   10'd3,   1'b0, 1'b0, 1'b1},  // R4 exact
        '{12'd3,   10'd3,   1'b1, 1'b0, 1'b0},  // R3 fast ignored
        '{12'd3,   10'd3,   1'b1, 1'b1, 1'b1},  // R3 slow selected
        '{12'd0,   10'd5,   1'b0, 1'b0, 1'b0},  // R5 zero parks
        '{12'd1,   10'd1,   1'b0, 1'b0, 1'b1},  // R4 minimum
        '{12'h105, 10'd260, 1'b0, 1'b0, 1'b0},  // R2 high part used
        '{12'h105, 10'd261, 1'b0, 1'b0, 1'b1},  // R2 high part used
        '{12'd5,   10'd6,   1'b0, 1'b0, 1'b1}   // R4 stays pending after reload
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ticks(input logic slow, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (slow) tick_slow = 1'b1; else tick_fast = 1'b1;
            @(negedge clk);
            tick_fast = 1'b0; tick_slow = 1'b0;
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq_n", {7'b0, irq_n}, 8'h01);
        chk("R1 firq_n", {7'b0, firq_n}, 8'h01);
        rd(3'd0, d); chk("R1 ctrl", d, 8'h00);
        rd(3'd1, d); chk("R1 irq_en", d, 8'h00);
        rd(3'd4, d); chk("R1 reload lo", d, 8'h00);

        // table walk: timer counting, selection, reload
        for (int v = 0; v < NV; v++) begin
            wr(3'd1, 8'h00);
            wr(3'd1, 8'h20);
            wr(3'd0, {5'b0, VECS[v].sel, 1'b0, 1'b1});
            wr(3'd4, VECS[v].rl[7:0]);
            wr(3'd3, {4'b0, VECS[v].rl[11:8]});
            ticks(VECS[v].line_slow, int'(VECS[v].nt));
            chk($sformatf("R2/R3/R4/R5 vec %0d", v), {7'b0, irq_n}, {7'b0, ~VECS[v].exp_low});
        end

        // R2: low byte alone does not start
        wr(3'd0, 8'h01);
        wr(3'd4, 8'h00); wr(3'd3, 8'h00);
        wr(3'd1, 8'h00); wr(3'd1, 8'h20);
        wr(3'd4, 8'h02);
        ticks(1'b0, 4);
        chk("R2 low write no start", {7'b0, irq_n}, 8'h01);
        wr(3'd3, 8'h00);
        ticks(1'b0, 1);
        chk("R2 started one short", {7'b0, irq_n}, 8'h01);
        ticks(1'b0, 1);
        chk("R2 started expiry", {7'b0, irq_n}, 8'h00);

        // R9: read returns timer flag but leaves it set
        rd(3'd1, d);
        chk("R9 read timer flag", d, 8'h20);
        chk("R9 timer flag kept", {7'b0, irq_n}, 8'h00);

        // R10: toggle clears
        wr(3'd1, 8'h00);
        wr(3'd1, 8'h20);
        chk("R10 toggle clears", {7'b0, irq_n}, 8'h01);

        // R4: periodic continuation
        ticks(1'b0, 1);
        chk("R4 period one short", {7'b0, irq_n}, 8'h01);
        ticks(1'b0, 1);
        chk("R4 second period", {7'b0, irq_n}, 8'h00);

        // stop the timer and clear
        wr(3'd3, 8'h00); wr(3'd4, 8'h00); wr(3'd3, 8'h00);
        wr(3'd1, 8'h00);

        // R6/R7: external edge
        wr(3'd0, 8'h03);
        wr(3'd1, 8'h01);
        wr(3'd2, 8'h00);
        @(negedge clk); src_in[0] = 1'b1;
        @(negedge clk);
        chk("R6 cartridge edge irq", {7'b0, irq_n}, 8'h00);
        chk("R7 firq not enabled", {7'b0, firq_n}, 8'h01);
        rd(3'd1, d);
        chk("R9 read ext flag", d, 8'h01);
        chk("R9 ext flag cleared", {7'b0, irq_n}, 8'h01);
        repeat (2) @(negedge clk);
        chk("R6 level no relatch", {7'b0, irq_n}, 8'h01);
        src_in[0] = 1'b0;

        // R7: disabled cause latched but masked
        @(negedge clk); src_in[3] = 1'b1;
        @(negedge clk); src_in[3] = 1'b0;
        chk("R7 masked cause", {7'b0, irq_n}, 8'h01);
        wr(3'd1, 8'h08);
        chk("R7 unmasked pending", {7'b0, irq_n}, 8'h00);
        rd(3'd1, d);
        chk("R9 vertical border flag", d, 8'h08);

        // R8: both outputs
        wr(3'd1, 8'h04);
        wr(3'd2, 8'h04);
        @(negedge clk); src_in[2] = 1'b1;
        @(negedge clk); src_in[2] = 1'b0;
        chk("R8 irq", {7'b0, irq_n}, 8'h00);
        chk("R8 firq", {7'b0, firq_n}, 8'h00);
        wr(3'd0, 8'h00);
        chk("R7 irq oe off", {7'b0, irq_n}, 8'h01);
        chk("R7 firq oe off", {7'b0, firq_n}, 8'h01);
        wr(3'd0, 8'h03);
        chk("R7 oe on again", {6'b0, irq_n, firq_n}, 8'h00);
        rd(3'd2, d);
        chk("R9 firq read", d, 8'h04);
        chk("R9 shared flag cleared", {6'b0, irq_n, firq_n}, 8'h03);

        summary();
    end

endmodule